// File: doc/BRIEF.md
# Grouped Interrupt Request Aggregator

This block gathers interrupt lines from four groups of sixteen sources each: a local bus group, a low-pin-count bus group, an on-chip/PCI device group and a non-maskable group. Every source passes through a two-flop synchronizer. Then a per-source trigger bit picks level or edge sensing, and a per-source polarity bit picks the active sense. The resulting request bits are gated by a per-source mask. They are folded into a 4-bit per-group summary and a single CPU interrupt line.

Software reaches the per-group configuration and request state through a synchronous register port. Reads have one cycle of latency. Each group has four 16-bit registers, selected by address bits [1:0]: 0 is mask, 1 is trigger, 2 is polarity and 3 is request. Address bits [4:2] hold the group index, which is also the group's summary bit position. The summary register is at address 16. Latched edge requests are acknowledged by writing zeros to the request register.

Top module: `irq_agg_top`

## Requirements
- R1: After reset every mask register reads 0xFFFF, every trigger and polarity register reads 0x0000, and summary_o, irq_o and all latched edge requests are 0.
- R2: A mask bit of 1 keeps its source out of summary_o and irq_o. A mask bit of 0 lets its pending request through. Writing 0xFFFF to a group's mask (addr g*4+0) blocks the whole group.
- R3: A source whose trigger bit (addr g*4+1) is 0 is level-sensitive. Its request bit at index equal to the source index follows the synchronized input. The input is taken as active high when its polarity bit (addr g*4+2) is 1 and active low when the bit is 0, and the request bit drops when the input goes inactive.
- R4: A source whose trigger bit is 1 latches its request bit on the transition into its active sense: a rising edge for polarity 1, a falling edge for polarity 0. The bit stays set after the input returns to inactive.
- R5: A write to a group's request register (addr g*4+3) clears each latched edge request whose write-data bit is 0 and keeps those whose bit is 1. Writing 0 therefore clears every latched request in the group.
- R6: summary_o bit g is the OR over group g of request AND NOT mask. Bit 0 is the local bus group, bit 1 the low-pin-count group, bit 2 the device group and bit 3 the non-maskable group.
- R7: irq_o is 1 exactly when any summary_o bit is 1, and the two change in the same cycle.
- R8: A read strobe with a register address returns that register's value on rdata at the next clock edge. Address 16 returns the summary in bits [3:0].
- R9: Writes to the summary address, and write-data bits aimed at level-sensitive request bits, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 64 | Asynchronous source lines, group g at bits [g*16+15:g*16] |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid the cycle after rd_en |
| summary_o | output | 4 | Per-group unmasked-pending summary |
| irq_o | output | 1 | CPU interrupt request |

## Verification
The hardest state to reach is a group in which latched edge requests and live level requests sit side by side, with an acknowledge write then clearing only part of the latch. The stimulus switches a whole group to edge mode first, so that the remaining inputs cannot raise stray level requests. It then pulses two sources, waits out the synchronizer, and writes a pattern that acknowledges one and keeps the other. The falling-edge case needs the trigger bit set while the input is idle-high in the active-low sense, so that no spurious edge is latched before the real one.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int GRP_CNT = 4;
  localparam int SRC_CNT = 16;

  typedef enum logic [1:0] {
    FLD_MASK = 2'd0,
    FLD_TRIG = 2'd1,
    FLD_POL  = 2'd2,
    FLD_REQ  = 2'd3
  } fld_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/irq_group.sv
module irq_group #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] src_sync,
  input  logic         wr_mask,
  input  logic         wr_trig,
  input  logic         wr_pol,
  input  logic         wr_req,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] trig_o,
  output logic [W-1:0] pol_o,
  output logic [W-1:0] req_o
);
  logic [W-1:0] mask_q;
  logic [W-1:0] trig_q;
  logic [W-1:0] pol_q;
  logic [W-1:0] latch_q;
  logic [W-1:0] prev_q;
  logic [W-1:0] active;
  logic [W-1:0] edge_hit;
  logic [W-1:0] keep;
  logic [W-1:0] latch_d;

  // active sense after polarity: pol=1 high-true, pol=0 low-true
  assign active   = src_sync ~^ pol_q;
  assign edge_hit = active & ~prev_q;
  assign keep     = wr_req ? wdata : '1;
  assign latch_d  = trig_q & ((latch_q & keep) | edge_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '1;
      trig_q  <= '0;
      pol_q   <= '0;
      latch_q <= '0;
      prev_q  <= '0;
    end else begin
      prev_q  <= active;
      latch_q <= latch_d;
      if (wr_mask) mask_q <= wdata;
      if (wr_trig) trig_q <= wdata;
      if (wr_pol)  pol_q  <= wdata;
    end
  end

  assign mask_o = mask_q;
  assign trig_o = trig_q;
  assign pol_o  = pol_q;
  assign req_o  = (trig_q & latch_q) | (~trig_q & active);
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
#(
  parameter int NGRP   = GRP_CNT,
  parameter int SRC_W  = SRC_CNT,
  parameter int ADDR_W = $clog2(NGRP * 4 + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NGRP*SRC_W-1:0]   src_i,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [SRC_W-1:0]        wdata,
  output logic [SRC_W-1:0]        rdata,
  output logic [NGRP-1:0]         summary_o,
  output logic                    irq_o
);
  localparam int SUM_ADDR = NGRP * 4;
  localparam int GSEL_W   = ADDR_W - 2;

  logic [NGRP*SRC_W-1:0] src_sync;
  logic [NGRP*SRC_W-1:0] all_mask;
  logic [NGRP*SRC_W-1:0] all_trig;
  logic [NGRP*SRC_W-1:0] all_pol;
  logic [NGRP*SRC_W-1:0] all_req;
  logic [NGRP-1:0]       sum_d;
  logic [NGRP-1:0]       sum_q;
  logic                  irq_q;
  logic [SRC_W-1:0]      rd_val;
  logic [SRC_W-1:0]      rdata_q;
  logic [GSEL_W-1:0]     gsel;
  fld_e                  fsel;

  assign gsel = addr[ADDR_W-1:2];
  assign fsel = fld_e'(addr[1:0]);

  irq_sync #(.W(NGRP*SRC_W)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (src_i),
    .q   (src_sync)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic hit;
    assign hit = wr_en && (gsel == GSEL_W'(g));

    irq_group #(.W(SRC_W)) u_grp (
      .clk      (clk),
      .rst      (rst),
      .src_sync (src_sync[g*SRC_W +: SRC_W]),
      .wr_mask  (hit && (fsel == FLD_MASK)),
      .wr_trig  (hit && (fsel == FLD_TRIG)),
      .wr_pol   (hit && (fsel == FLD_POL)),
      .wr_req   (hit && (fsel == FLD_REQ)),
      .wdata    (wdata),
      .mask_o   (all_mask[g*SRC_W +: SRC_W]),
      .trig_o   (all_trig[g*SRC_W +: SRC_W]),
      .pol_o    (all_pol[g*SRC_W +: SRC_W]),
      .req_o    (all_req[g*SRC_W +: SRC_W])
    );

    assign sum_d[g] = |(all_req[g*SRC_W +: SRC_W] & ~all_mask[g*SRC_W +: SRC_W]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q <= '0;
      irq_q <= 1'b0;
    end else begin
      sum_q <= sum_d;
      irq_q <= |sum_d;
    end
  end

  always_comb begin
    rd_val = '0;
    if (addr == ADDR_W'(SUM_ADDR)) begin
      rd_val[NGRP-1:0] = sum_q;
    end else begin
      for (int g = 0; g < NGRP; g++) begin
        if (gsel == GSEL_W'(g)) begin
          case (fsel)
            FLD_MASK: rd_val = all_mask[g*SRC_W +: SRC_W];
            FLD_TRIG: rd_val = all_trig[g*SRC_W +: SRC_W];
            FLD_POL:  rd_val = all_pol[g*SRC_W +: SRC_W];
            default:  rd_val = all_req[g*SRC_W +: SRC_W];
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_val;
  end

  assign rdata     = rdata_q;
  assign summary_o = sum_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
  parameter int NGRP  = 4,
  parameter int SRC_W = 16
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  wr_en,
  input logic [NGRP-1:0]       summary_o,
  input logic                  irq_o,
  input logic [NGRP*SRC_W-1:0] all_mask,
  input logic [NGRP*SRC_W-1:0] all_trig,
  input logic [NGRP*SRC_W-1:0] all_req
);
  // R1: first cycle out of reset shows no request
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (summary_o == '0 && !irq_o));

  // R7: cpu line tracks the summary
  a_r7_irq_is_any_summary: assert property (@(posedge clk) disable iff (rst)
    irq_o == (summary_o != '0));

  for (genvar g = 0; g < NGRP; g++) begin : g_chk
    // R2: a fully masked group never shows in the summary
    a_r2_full_mask_blocks: assert property (@(posedge clk) disable iff (rst)
      (&all_mask[g*SRC_W +: SRC_W]) |=> !summary_o[g]);

    // R6: any unmasked pending source raises its group bit
    a_r6_pending_sets_summary: assert property (@(posedge clk) disable iff (rst)
      ((all_req[g*SRC_W +: SRC_W] & ~all_mask[g*SRC_W +: SRC_W]) != '0) |=> summary_o[g]);

    // R4: latched edge requests persist while nothing is written
    a_r4_edge_latch_holds: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> (($past(all_req[g*SRC_W +: SRC_W] & all_trig[g*SRC_W +: SRC_W])
                   & ~all_req[g*SRC_W +: SRC_W]) == '0));
  end
endmodule

bind irq_agg_top irq_agg_chk #(.NGRP(NGRP), .SRC_W(SRC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .summary_o (summary_o),
  .irq_o     (irq_o),
  .all_mask  (all_mask),
  .all_trig  (all_trig),
  .all_req   (all_req)
);

// File: tb/irq_agg_top_bench.sv
module irq_agg_top_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [63:0] src;
  logic        wr_en, rd_en;
  logic [4:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic [3:0]  summary_o;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  irq_agg_top u_irq_agg_top (
    .clk (clk), .rst (rst), .src_i (src), .wr_en (wr_en), .rd_en (rd_en),
    .addr (addr), .wdata (wdata), .rdata (rdata),
    .summary_o (summary_o), .irq_o (irq_o)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    for (int g = 0; g < 4; g++) begin
      rd(5'(g*4 + 0), v); check(v == 16'hFFFF, "R1 mask", v, 16'hFFFF);
      rd(5'(g*4 + 1), v); check(v == 16'h0000, "R1 trig", v, 16'h0000);
      rd(5'(g*4 + 2), v); check(v == 16'h0000, "R1 pol", v, 16'h0000);
    end
    check(summary_o == 4'h0, "R1 summary", {12'h0, summary_o}, 16'h0);
    check(irq_o == 1'b0, "R1 irq", {15'h0, irq_o}, 16'h0);
  endtask

  task automatic t_level();
    logic [15:0] v;
    // low-pin-count group is index 1; source 4 active high
    wr(5'd6, 16'h0010);
    wr(5'd4, 16'hFFEF);
    settle();
    check(summary_o == 4'h0, "R3 idle", {12'h0, summary_o}, 16'h0);
    src[16+4] = 1'b1;
    settle();
    check(summary_o == 4'b0010, "R6 lpc bit", {12'h0, summary_o}, 16'h0002);
    check(irq_o == 1'b1, "R7 irq up", {15'h0, irq_o}, 16'h1);
    rd(5'd7, v);  // inactive low-true sources read as active too
    check(v == 16'hFFFF, "R3 req", v, 16'hFFFF);
    // R9: writing zeros to a level request register changes nothing
    wr(5'd7, 16'h0000);
    rd(5'd7, v);
    check(v == 16'hFFFF, "R9 level req write", v, 16'hFFFF);
    // R9: summary address write ignored
    wr(5'd16, 16'h0000);
    rd(5'd16, v);
    check(v == 16'h0002, "R9 summary write", v, 16'h0002);
    src[16+4] = 1'b0;
    settle();
    check(summary_o == 4'h0, "R3 drop", {12'h0, summary_o}, 16'h0);
    check(irq_o == 1'b0, "R7 irq down", {15'h0, irq_o}, 16'h0);
  endtask

  task automatic t_mask();
    // local bus group 0, source 3 active low (pol 0), input idle low
    wr(5'd0, 16'hFFF7);
    settle();
    check(summary_o == 4'b0001, "R3 active low", {12'h0, summary_o}, 16'h0001);
    src[3] = 1'b1;
    settle();
    check(summary_o == 4'h0, "R3 active low off", {12'h0, summary_o}, 16'h0);
    src[3] = 1'b0;
    settle();
    wr(5'd0, 16'hFFFF);
    settle();
    check(summary_o == 4'h0, "R2 mask blocks", {12'h0, summary_o}, 16'h0);
    check(irq_o == 1'b0, "R2 irq blocked", {15'h0, irq_o}, 16'h0);
  endtask

  task automatic t_edge();
    logic [15:0] v;
    // device group 2: all edge, active high, sources 5 and 9 unmasked
    wr(5'd9, 16'hFFFF);
    wr(5'd10, 16'hFFFF);
    wr(5'd8, 16'hFDDF);
    settle();
    rd(5'd11, v);
    check(v == 16'h0000, "R4 no edge yet", v, 16'h0000);
    src[32+5] = 1'b1; src[32+9] = 1'b1;
    repeat (3) @(negedge clk);
    src[32+5] = 1'b0; src[32+9] = 1'b0;
    settle();
    rd(5'd11, v);
    check(v == 16'h0220, "R4 latched", v, 16'h0220);
    check(summary_o == 4'b0100, "R6 dev bit", {12'h0, summary_o}, 16'h0004);
    wr(5'd11, 16'hFFDF);
    rd(5'd11, v);
    check(v == 16'h0200, "R5 partial ack", v, 16'h0200);
    wr(5'd11, 16'h0000);
    rd(5'd11, v);
    check(v == 16'h0000, "R5 clear all", v, 16'h0000);
    settle();
    check(summary_o == 4'h0, "R5 summary clear", {12'h0, summary_o}, 16'h0);
  endtask

  task automatic t_fall();
    logic [15:0] v;
    // non-maskable group 3: all edge, active low, source 0 unmasked
    wr(5'd13, 16'hFFFF);
    wr(5'd12, 16'hFFFE);
    settle();
    src[48] = 1'b1;
    settle();
    rd(5'd15, v);
    check(v == 16'h0000, "R4 rise ignored", v, 16'h0000);
    src[48] = 1'b0;
    settle();
    rd(5'd15, v);
    check(v == 16'h0001, "R4 fall latched", v, 16'h0001);
    check(summary_o == 4'b1000, "R6 nmi bit", {12'h0, summary_o}, 16'h0008);
    wr(5'd15, 16'h0000);
    settle();
    check(summary_o == 4'h0, "R5 nmi ack", {12'h0, summary_o}, 16'h0);
  endtask

  task automatic t_read();
    wr(5'd14, 16'h1234);
    @(negedge clk);
    rd_en = 1'b1; addr = 5'd14;
    @(negedge clk);
    rd_en = 1'b0; addr = 5'd0;
    check(rdata == 16'h1234, "R8 latency", rdata, 16'h1234);
    @(negedge clk);
    check(rdata == 16'h1234, "R8 hold", rdata, 16'h1234);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; src = '0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_level();
    t_mask();
    t_edge();
    t_fall();
    t_read();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule